// File: doc/BRIEF.md
# Audio Codec Control Register Bank

This block holds the 16-bit control words of an audio codec: mixer volumes, mute bits, extended-audio status and the sample-rate words, addressed with a 7-bit byte address in which only even addresses name a word. A host writes a word with a strobe. A read strobe returns one word on the next cycle, together with the echoed address and a flag for each of the two slots: one for the address slot and one for the data slot.

A write does not always store the word it is given. Depending on the address, the write is dropped, has a fixed bit pattern forced into part of the word, is replaced by a fixed rate value, or acts as a software reset. A read can also differ from the stored word. In full-compliance mode, bits marked reserved are cleared. The three converter-rate words read back one of two fixed rate values, chosen by an internal flag. A few control flip-flops copy register bits so that the rest of the codec can use them directly.

Top module: `codec_reg_bank`

## Requirements
- R1: After hardware reset, every implemented word reads its default: 00h=0000h, 02h/04h/06h=8000h, 0Ch=8008h, 18h=8808h, 1Ah=0000h, 1Ch=8000h, 20h=0000h, 26h=000Eh, 28h=0001h, 2Ah=01C0h, 2Ch/2Eh/30h/32h/34h=BB80h, 7Ch=8384h, 7Eh=7600h. In the same state, mute_o=1, vra_o=0 and rate_44k_o=0.
- R2: A read strobe in cycle n gives rvalid_o=1, rd_slot_vld_o=2'b11, raddr_o equal to the requested address, and rdata_o in cycle n+1. In any cycle that does not follow a read strobe, rvalid_o=0 and rd_slot_vld_o=2'b00.
- R3: A plain write stores all 16 bits, reserved bits included. With full-compliance mode off, a read returns the stored word unchanged.
- R4: Full-compliance mode is set by cfg_full_i when cfg_we_i is high. It is on after hardware reset and is not changed by a software reset. While it is on, read data is ANDed with the word's implemented-bit mask: 00h/28h/2Ch/2Eh/30h/32h/34h/7Ch/7Eh=FFFFh, 02h/04h/06h=BF3Fh, 0Ch=801Fh, 18h=9F1Fh, 1Ah=0707h, 1Ch=8F0Fh, 20h=B380h, 26h=FF0Fh, 2Ah=3BFFh.
- R5: Any write to 00h is a software reset. It returns every stored word, mute_o, vra_o and rate_44k_o to their hardware-reset values.
- R6: Writes to 7Ch, 7Eh and 28h have no effect.
- R7: A write to 26h stores data bits 15:4 and forces bits 3:0 to 4'b1110.
- R8: A write to 2Ah stores data bits 15:10 and 5:0 and forces bits 9:6 to 4'b0111.
- R9: A write to 32h or 34h stores BB80h, whatever the data.
- R10: Reads of 2Ch, 2Eh and 30h return AC44h when rate_44k_o=1 and BB80h otherwise. A write to any of the three sets rate_44k_o to 1 if the data is AC44h and to 0 for any other data.
- R11: A read of an odd address returns rdata_o=0000h, echoes that odd address on raddr_o, and sets both slot-valid bits.
- R12: An even address outside the list in R1 reads 0000h. Writes to such an address, and writes to any odd address, have no effect.
- R13: When a read and a write reach the same address in the same cycle, the read returns the value from before the write.
- R14: mute_o follows bit 15 of 02h and vra_o follows bit 0 of 2Ah. Both update on the clock edge that stores the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load strobe for the full-compliance bit |
| cfg_full_i | input | 1 | New value of the full-compliance bit |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 16 | Write data |
| rvalid_o | output | 1 | Read-data valid pulse |
| rd_slot_vld_o | output | 2 | Slot valid flags: bit 0 address slot, bit 1 data slot |
| raddr_o | output | 7 | Echoed read address |
| rdata_o | output | 16 | Read data |
| mute_o | output | 1 | Master-mute control flip-flop |
| vra_o | output | 1 | Variable-rate enable control flip-flop |
| rate_44k_o | output | 1 | Rate flag; 1 selects AC44h |

## Verification
Faults in the stored words only become visible when the affected address is read. A write that is shaped wrongly therefore shows up one cycle after the next read of that word. It shows up at once on mute_o or vra_o if the corrupted bit is one of those two. A wrong rate flag is visible on rate_44k_o on the cycle after the write, and on every later read of the three rate words. A software reset that misses some state leaves a stale bit that the next read-back sweep exposes. Because of this, the bench compares every output on every clock and repeatedly reads back the whole implemented map.

// File: rtl/codec_reg_pkg.sv
package codec_reg_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int IDX_W  = ADDR_W - 1;
  localparam int WORDS  = 2 ** IDX_W;

  localparam logic [DATA_W-1:0] RATE_48K = 16'hBB80;
  localparam logic [DATA_W-1:0] RATE_44K = 16'hAC44;

  typedef enum logic [2:0] {
    WK_PLAIN, WK_DROP, WK_SRST, WK_LOW_NIB, WK_MID_NIB, WK_FIXED, WK_RATE
  } wr_kind_e;

  function automatic logic impl_f(logic [ADDR_W-1:0] a);
    case (a)
      7'h00, 7'h02, 7'h04, 7'h06, 7'h0C, 7'h18, 7'h1A, 7'h1C, 7'h20,
      7'h26, 7'h28, 7'h2A, 7'h2C, 7'h2E, 7'h30, 7'h32, 7'h34,
      7'h7C, 7'h7E: return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] dflt_f(logic [ADDR_W-1:0] a);
    case (a)
      7'h02, 7'h04, 7'h06, 7'h1C:                return 16'h8000;
      7'h0C:                                     return 16'h8008;
      7'h18:                                     return 16'h8808;
      7'h26:                                     return 16'h000E;
      7'h28:                                     return 16'h0001;
      7'h2A:                                     return 16'h01C0;
      7'h2C, 7'h2E, 7'h30, 7'h32, 7'h34:         return RATE_48K;
      7'h7C:                                     return 16'h8384;
      7'h7E:                                     return 16'h7600;
      default:                                   return 16'h0000;
    endcase
  endfunction

  // 1 = implemented bit; unlisted addresses have no bits
  function automatic logic [DATA_W-1:0] mask_f(logic [ADDR_W-1:0] a);
    case (a)
      7'h00, 7'h28, 7'h2C, 7'h2E, 7'h30, 7'h32, 7'h34,
      7'h7C, 7'h7E:                              return 16'hFFFF;
      7'h02, 7'h04, 7'h06:                       return 16'hBF3F;
      7'h0C:                                     return 16'h801F;
      7'h18:                                     return 16'h9F1F;
      7'h1A:                                     return 16'h0707;
      7'h1C:                                     return 16'h8F0F;
      7'h20:                                     return 16'hB380;
      7'h26:                                     return 16'hFF0F;
      7'h2A:                                     return 16'h3BFF;
      default:                                   return 16'h0000;
    endcase
  endfunction

  function automatic wr_kind_e wr_kind_f(logic [ADDR_W-1:0] a);
    case (a)
      7'h00:               return WK_SRST;
      7'h28, 7'h7C, 7'h7E: return WK_DROP;
      7'h26:               return WK_LOW_NIB;
      7'h2A:               return WK_MID_NIB;
      7'h32, 7'h34:        return WK_FIXED;
      7'h2C, 7'h2E, 7'h30: return WK_RATE;
      default:             return impl_f(a) ? WK_PLAIN : WK_DROP;
    endcase
  endfunction

  function automatic logic rate_rd_f(logic [ADDR_W-1:0] a);
    return (a == 7'h2C) || (a == 7'h2E) || (a == 7'h30);
  endfunction
endpackage

// File: rtl/codec_wr_shaper.sv
module codec_wr_shaper
  import codec_reg_pkg::*;
(
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              st_we_o,
  output logic [IDX_W-1:0]  st_idx_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              srst_o,
  output logic              rate_we_o,
  output logic              rate_44k_o,
  output logic              mute_we_o,
  output logic              mute_d_o,
  output logic              vra_we_o,
  output logic              vra_d_o
);
  wr_kind_e kind;
  logic     even_we;

  assign kind     = wr_kind_f(addr_i);
  assign even_we  = we_i && !addr_i[0];
  assign st_idx_o = addr_i[ADDR_W-1:1];

  always_comb begin
    st_we_o    = 1'b0;
    st_data_o  = wdata_i;
    srst_o     = 1'b0;
    rate_we_o  = 1'b0;
    rate_44k_o = 1'b0;
    if (even_we) begin
      case (kind)
        WK_SRST:    srst_o = 1'b1;
        WK_DROP:    st_we_o = 1'b0;
        WK_LOW_NIB: begin
          st_we_o   = 1'b1;
          st_data_o = {wdata_i[15:4], 4'b1110};
        end
        WK_MID_NIB: begin
          st_we_o   = 1'b1;
          st_data_o = {wdata_i[15:10], 4'b0111, wdata_i[5:0]};
        end
        WK_FIXED: begin
          st_we_o   = 1'b1;
          st_data_o = RATE_48K;
        end
        WK_RATE: begin
          st_we_o    = 1'b1;
          rate_we_o  = 1'b1;
          rate_44k_o = (wdata_i == RATE_44K);
        end
        default:    st_we_o = 1'b1;
      endcase
    end
  end

  assign mute_we_o = st_we_o && (addr_i == 7'h02);
  assign mute_d_o  = st_data_o[15];
  assign vra_we_o  = st_we_o && (addr_i == 7'h2A);
  assign vra_d_o   = st_data_o[0];
endmodule

// File: rtl/codec_reg_store.sv
module codec_reg_store
  import codec_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              st_we_i,
  input  logic [IDX_W-1:0]  st_idx_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] words [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(2 * g);
    if (impl_f(WADDR)) begin : g_ff
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   q <= dflt_f(WADDR);
        else if (srst_i)                               q <= dflt_f(WADDR);
        else if (st_we_i && st_idx_i == IDX_W'(g))     q <= st_data_i;
      end
      assign words[g] = q;
    end else begin : g_nil
      assign words[g] = '0;
    end
  end

  assign rd_word_o = words[rd_idx_i];
endmodule

// File: rtl/codec_ctrl_ff.sv
module codec_ctrl_ff
  import codec_reg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic mute_we_i,
  input  logic mute_d_i,
  input  logic vra_we_i,
  input  logic vra_d_i,
  input  logic rate_we_i,
  input  logic rate_44k_i,
  input  logic cfg_we_i,
  input  logic cfg_full_i,
  output logic mute_o,
  output logic vra_o,
  output logic rate_44k_o,
  output logic fc_o
);
  localparam logic [DATA_W-1:0] MIX_DFLT = dflt_f(7'h02);
  localparam logic [DATA_W-1:0] EXT_DFLT = dflt_f(7'h2A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_o     <= MIX_DFLT[15];
      vra_o      <= EXT_DFLT[0];
      rate_44k_o <= 1'b0;
    end else if (srst_i) begin
      mute_o     <= MIX_DFLT[15];
      vra_o      <= EXT_DFLT[0];
      rate_44k_o <= 1'b0;
    end else begin
      if (mute_we_i) mute_o     <= mute_d_i;
      if (vra_we_i)  vra_o      <= vra_d_i;
      if (rate_we_i) rate_44k_o <= rate_44k_i;
    end
  end

  // compliance bit survives software reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fc_o <= 1'b1;
    else if (cfg_we_i) fc_o <= cfg_full_i;
  end
endmodule

// File: rtl/codec_rd_path.sv
module codec_rd_path
  import codec_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] rd_word_i,
  input  logic              fc_i,
  input  logic              rate_44k_i,
  output logic              rvalid_o,
  output logic [1:0]        slot_vld_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_next;

  always_comb begin
    if (addr_i[0] || !impl_f(addr_i))  rd_next = '0;
    else if (rate_rd_f(addr_i))        rd_next = rate_44k_i ? RATE_44K : RATE_48K;
    else if (fc_i)                     rd_next = rd_word_i & mask_f(addr_i);
    else                               rd_next = rd_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o   <= 1'b0;
      slot_vld_o <= 2'b00;
      raddr_o    <= '0;
      rdata_o    <= '0;
    end else begin
      rvalid_o   <= re_i;
      slot_vld_o <= {2{re_i}};
      if (re_i) begin
        raddr_o <= addr_i;
        rdata_o <= rd_next;
      end
    end
  end
endmodule

// File: rtl/codec_reg_bank.sv
module codec_reg_bank
  import codec_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_full_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rvalid_o,
  output logic [1:0]        rd_slot_vld_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mute_o,
  output logic              vra_o,
  output logic              rate_44k_o
);
  logic              st_we, srst, rate_we, rate_44k_d;
  logic              mute_we, mute_d, vra_we, vra_d, fc_q;
  logic [IDX_W-1:0]  st_idx;
  logic [DATA_W-1:0] st_data, rd_word;

  codec_wr_shaper u_shape (
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .st_we_o    (st_we),
    .st_idx_o   (st_idx),
    .st_data_o  (st_data),
    .srst_o     (srst),
    .rate_we_o  (rate_we),
    .rate_44k_o (rate_44k_d),
    .mute_we_o  (mute_we),
    .mute_d_o   (mute_d),
    .vra_we_o   (vra_we),
    .vra_d_o    (vra_d)
  );

  codec_reg_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (srst),
    .st_we_i   (st_we),
    .st_idx_i  (st_idx),
    .st_data_i (st_data),
    .rd_idx_i  (addr_i[ADDR_W-1:1]),
    .rd_word_o (rd_word)
  );

  codec_ctrl_ff u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .srst_i     (srst),
    .mute_we_i  (mute_we),
    .mute_d_i   (mute_d),
    .vra_we_i   (vra_we),
    .vra_d_i    (vra_d),
    .rate_we_i  (rate_we),
    .rate_44k_i (rate_44k_d),
    .cfg_we_i   (cfg_we_i),
    .cfg_full_i (cfg_full_i),
    .mute_o     (mute_o),
    .vra_o      (vra_o),
    .rate_44k_o (rate_44k_o),
    .fc_o       (fc_q)
  );

  codec_rd_path u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .re_i       (re_i),
    .addr_i     (addr_i),
    .rd_word_i  (rd_word),
    .fc_i       (fc_q),
    .rate_44k_i (rate_44k_o),
    .rvalid_o   (rvalid_o),
    .slot_vld_o (rd_slot_vld_o),
    .raddr_o    (raddr_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/codec_reg_bank_chk.sv
module codec_reg_bank_chk
  import codec_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rvalid_o,
  input logic [1:0]        rd_slot_vld_o,
  input logic [ADDR_W-1:0] raddr_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              mute_o,
  input logic              vra_o,
  input logic              rate_44k_o,
  input logic              fc_i
);
  AST_READ_VALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> (rvalid_o && rd_slot_vld_o == 2'b11)); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> (!rvalid_o && rd_slot_vld_o == 2'b00)); // R2
  AST_ODD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i[0]) |=> (rdata_o == '0 && raddr_o == $past(addr_i))); // R11
  AST_UNIMPL_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !addr_i[0] && !impl_f(addr_i)) |=> (rdata_o == '0)); // R12
  AST_RATE_READ_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && rate_rd_f(addr_i)) |=> (rdata_o == RATE_48K || rdata_o == RATE_44K)); // R10
  AST_VENDOR_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == 7'h7C) |=> (rdata_o == 16'h8384)); // R6
  AST_COMPLIANT_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && fc_i) |=> ((rdata_o & ~mask_f($past(addr_i))) == '0)); // R4
  AST_SOFT_RESET_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 7'h00) |=> (mute_o && !vra_o && !rate_44k_o)); // R5
  AST_VRA_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 7'h2A) |=> (vra_o == $past(wdata_i[0]))); // R14
endmodule

bind codec_reg_bank codec_reg_bank_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .we_i          (we_i),
  .re_i          (re_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rvalid_o      (rvalid_o),
  .rd_slot_vld_o (rd_slot_vld_o),
  .raddr_o       (raddr_o),
  .rdata_o       (rdata_o),
  .mute_o        (mute_o),
  .vra_o         (vra_o),
  .rate_44k_o    (rate_44k_o),
  .fc_i          (fc_q)
);

// File: tb/sim_codec_reg_bank.sv
`timescale 1ns/1ps
module sim_codec_reg_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_full_i = 1'b0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [6:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        rvalid_o, mute_o, vra_o, rate_44k_o;
  logic [1:0]  rd_slot_vld_o;
  logic [6:0]  raddr_o;
  logic [15:0] rdata_o;

  always #4 clk_i = ~clk_i;

  codec_reg_bank u0 (.*);

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  logic [15:0] mem [128];
  bit          flag44, fc;
  bit          e_rv;
  logic [6:0]  e_addr;
  logic [15:0] e_data;

  function automatic bit m_impl(int a);
    int list [19] = '{'h00,'h02,'h04,'h06,'h0C,'h18,'h1A,'h1C,'h20,'h26,'h28,'h2A,
                      'h2C,'h2E,'h30,'h32,'h34,'h7C,'h7E};
    foreach (list[k]) if (list[k] == a) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [15:0] m_def(int a);
    if (a inside {'h02,'h04,'h06,'h1C}) return 16'h8000;
    if (a == 'h0C) return 16'h8008;
    if (a == 'h18) return 16'h8808;
    if (a == 'h26) return 16'h000E;
    if (a == 'h28) return 16'h0001;
    if (a == 'h2A) return 16'h01C0;
    if (a inside {'h2C,'h2E,'h30,'h32,'h34}) return 16'hBB80;
    if (a == 'h7C) return 16'h8384;
    if (a == 'h7E) return 16'h7600;
    return 16'h0000;
  endfunction

  function automatic logic [15:0] m_mask(int a);
    if (a inside {'h02,'h04,'h06}) return 16'hBF3F;
    if (a == 'h0C) return 16'h801F;
    if (a == 'h18) return 16'h9F1F;
    if (a == 'h1A) return 16'h0707;
    if (a == 'h1C) return 16'h8F0F;
    if (a == 'h20) return 16'hB380;
    if (a == 'h26) return 16'hFF0F;
    if (a == 'h2A) return 16'h3BFF;
    return m_impl(a) ? 16'hFFFF : 16'h0000;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 128; i++) mem[i] = m_impl(i) ? m_def(i) : 16'h0;
    flag44 = 1'b0;
  endtask

  function automatic logic [15:0] m_read(int a);
    if (a % 2 == 1 || !m_impl(a)) return 16'h0;
    if (a inside {'h2C,'h2E,'h30}) return flag44 ? 16'hAC44 : 16'hBB80;
    return fc ? (mem[a] & m_mask(a)) : mem[a];
  endfunction

  task automatic m_write(int a, logic [15:0] d);
    if (a == 0) begin m_reset(); return; end
    if (a % 2 == 1 || !m_impl(a) || a inside {'h7C,'h7E,'h28}) return;
    if (a == 'h26)                  mem[a] = {d[15:4], 4'b1110};
    else if (a == 'h2A)             mem[a] = {d[15:10], 4'b0111, d[5:0]};
    else if (a inside {'h32,'h34})  mem[a] = 16'hBB80;
    else begin
      mem[a] = d;
      if (a inside {'h2C,'h2E,'h30}) flag44 = (d == 16'hAC44);
    end
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk("R2", 16'(rvalid_o), 16'(e_rv));
    if (e_rv) begin
      chk(tag, rdata_o, e_data);
      chk(e_addr[0] ? "R11" : "R2", 16'(raddr_o), 16'(e_addr));
      chk(e_addr[0] ? "R11" : "R2", 16'(rd_slot_vld_o), 16'h3);
    end else begin
      chk("R2", 16'(rd_slot_vld_o), 16'h0);
    end
    chk("R14", 16'(mute_o), 16'(mem['h02][15]));
    chk("R14", 16'(vra_o), 16'(mem['h2A][0]));
    chk("R10", 16'(rate_44k_o), 16'(flag44));
  endtask

  // drive at negedge, compare at the following negedge
  task automatic step(bit we, bit re, int a, logic [15:0] d, bit cw, bit cv, string tag);
    we_i = we; re_i = re; addr_i = 7'(a); wdata_i = d;
    cfg_we_i = cw; cfg_full_i = cv;
    e_rv = re; e_addr = 7'(a);
    e_data = re ? m_read(a) : 16'h0;
    if (cw) fc = cv;
    if (we) m_write(a, d);
    @(negedge clk_i);
    compare(tag);
  endtask

  task automatic wr(int a, logic [15:0] d, string tag); step(1, 0, a, d, 0, 0, tag); endtask
  task automatic rd(int a, string tag);                step(0, 1, a, 16'h0, 0, 0, tag); endtask
  task automatic set_fc(bit v);                        step(0, 0, 0, 16'h0, 1, v, "R4"); endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 128; a += 2) if (m_impl(a)) rd(a, tag);
  endtask

  task automatic hw_reset();
    rst_ni = 1'b0; we_i = 0; re_i = 0; cfg_we_i = 0;
    repeat (2) @(negedge clk_i);
    m_reset(); fc = 1'b1; e_rv = 1'b0;
    rst_ni = 1'b1;
    compare("R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    hw_reset();
    sweep("R1");
    rd('h08, "R12"); rd('h7A, "R12");

    // full-compliance masking versus raw word
    wr('h02, 16'hFFFF, "R14"); rd('h02, "R4");
    wr('h20, 16'hFFFF, "R3");  rd('h20, "R4");
    set_fc(0);
    rd('h02, "R3"); rd('h20, "R3");
    wr('h02, 16'h0000, "R14"); rd('h02, "R3");

    // forced bit patterns
    wr('h26, 16'hABCD, "R7"); rd('h26, "R7");
    wr('h26, 16'h0001, "R7"); rd('h26, "R7");
    wr('h2A, 16'hFFFF, "R8"); rd('h2A, "R8");
    wr('h2A, 16'h0000, "R8"); rd('h2A, "R8");
    wr('h2A, 16'h5A25, "R8"); rd('h2A, "R8");

    // fixed value on ADC rate words
    wr('h32, 16'h1234, "R9"); rd('h32, "R9");
    wr('h34, 16'hAC44, "R9"); rd('h34, "R9");

    // read-only words
    wr('h7C, 16'h0000, "R6"); wr('h7E, 16'hFFFF, "R6"); wr('h28, 16'hFFFF, "R6");
    rd('h7C, "R6"); rd('h7E, "R6"); rd('h28, "R6");

    // rate flag shared by three words
    wr('h2E, 16'hAC44, "R10");
    rd('h2C, "R10"); rd('h2E, "R10"); rd('h30, "R10");
    wr('h30, 16'hAC45, "R10"); rd('h2C, "R10");
    wr('h2C, 16'hAC44, "R10"); rd('h30, "R10");

    // odd addresses
    rd('h03, "R11"); rd('h7F, "R11"); rd('h27, "R11");
    wr('h03, 16'hFFFF, "R12"); rd('h02, "R12");

    // unimplemented even address
    wr('h08, 16'hFFFF, "R12"); rd('h08, "R12");

    // read and write to the same address in one cycle
    step(1, 1, 'h1A, 16'hFFFF, 0, 0, "R13"); rd('h1A, "R3");
    step(1, 1, 'h02, 16'h8000, 0, 0, "R13"); rd('h02, "R13");
    step(1, 1, 'h2C, 16'h0000, 0, 0, "R13"); rd('h2C, "R10");

    // masking back on
    set_fc(1);
    wr('h0C, 16'hFFFF, "R4"); rd('h0C, "R4"); rd('h1A, "R4"); rd('h2A, "R4");
    set_fc(0);

    // software reset: words and flops to defaults, compliance bit kept
    wr('h2E, 16'hAC44, "R10"); wr('h02, 16'h7FFF, "R14"); wr('h2A, 16'h0001, "R14");
    wr('h00, 16'h1234, "R5");
    sweep("R5");

    // hardware reset restores compliance mode
    wr('h18, 16'hFFFF, "R3");
    hw_reset();
    sweep("R1");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule